// File: doc/BRIEF.md
# DMA Interrupt Flag Aggregator

This block gathers the status events of a two-channel ADC-to-memory DMA engine into sticky flags and reduces them to a single level-sensitive interrupt request. The engine signals each condition with a one-cycle pulse. The conditions are: all queued operations finished with the engine idle, an overflow warning per channel, an overflow error per channel, the repeat counter reaching its programmed limit, and an end-of-operation instruction being reached. Each pulse sets its own flag, and the flag stays set until software clears it.

Software reaches the flags through two 8-bit registers, a status/control register and a configuration register. Writing 0 to a flag bit clears that flag, and writing 1 leaves it alone. The enable bits are ordinary read/write bits. The enables are mixed. The completion flag and both error flags always request an interrupt. One shared enable gates both channels' warning flags. The repeat-limit flag and the end-of-operation flag each have their own enable. A small two-state machine, quiet and raised, registers the request so that it changes on the same clock edge as the flags and enables that drive it.

Top module: `dmairq_agg`

## Requirements
- R1: While `rst_n` is low and after it returns high with no other activity, every flag and every enable is 0, `irq_req` is 0 and both registers read 0x00.
- R2: A one-cycle pulse on any event input sets its flag at the next rising clock edge. The flag then stays set after the pulse ends. Register 0 (`reg_sel`=0) bits: 0 completion, 1 error ch0, 2 error ch1, 3 warning ch0, 4 warning ch1, 5 warning enable. Register 1 bits: 0 end-of-operation flag, 1 its enable, 2 repeat-limit flag, 3 its enable.
- R3: A register write with 0 in a flag bit clears that flag. A 1 in a flag bit leaves the flag unchanged. Writes to one register never touch flags in the other register.
- R4: When an event pulse and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R5: A set completion flag or error flag drives `irq_req` high whatever the enable bits hold.
- R6: The warning enable (register 0 bit 5) gates both warning flags together. A set warning flag raises `irq_req` only while that enable is 1.
- R7: The repeat-limit flag raises `irq_req` only while register 1 bit 3 is 1. The end-of-operation flag raises it only while register 1 bit 1 is 1.
- R8: Flags are set even while their enable is 0. Writing an enable to 1 or 0 raises or drops `irq_req` at the next edge, with no event needed.
- R9: `irq_req` changes on the same edge as the flag or enable change that causes it. It stays low when no flag contributes.
- R10: Unused bits (register 0 bits 7:6, register 1 bits 7:4) read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_done | input | 1 | Pulse: all operations finished and engine idle |
| ev_warn | input | 2 | Pulse per channel: new sample while buffer still full |
| ev_err | input | 2 | Pulse per channel: sample discarded |
| ev_rep | input | 1 | Pulse: repeat counter reached its limit |
| ev_eop | input | 1 | Pulse: end-of-operation instruction reached |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status/control, 1 configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Level interrupt request |

## Verification
The assertions assume that every event input and the write strobe is either a clean single-cycle pulse or a held level, sampled at the rising edge, and that no input is X once reset is released. Nothing is assumed about how events interleave with writes, so a collision between an event and a clear must resolve to set. The stimulus changes inputs only on the falling edge and holds them for whole cycles. The random phase mixes events and writes freely, with collisions included, because the flag logic must tolerate any mix.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int NUM_FLAGS = 7;
    localparam int NUM_EN    = 3;
    localparam int REG_W     = 8;

    // flag vector positions
    localparam int FL_DONE  = 0;
    localparam int FL_ERR0  = 1;
    localparam int FL_ERR1  = 2;
    localparam int FL_WARN0 = 3;
    localparam int FL_WARN1 = 4;
    localparam int FL_REP   = 5;
    localparam int FL_EOP   = 6;

    // enable vector positions
    localparam int EN_WARN = 0;
    localparam int EN_REP  = 1;
    localparam int EN_EOP  = 2;

    // register 0 bit positions
    localparam int R0_DONE  = 0;
    localparam int R0_ERR0  = 1;
    localparam int R0_ERR1  = 2;
    localparam int R0_WARN0 = 3;
    localparam int R0_WARN1 = 4;
    localparam int R0_WEN   = 5;

    // register 1 bit positions
    localparam int R1_EOP   = 0;
    localparam int R1_EOPEN = 1;
    localparam int R1_REP   = 2;
    localparam int R1_REPEN = 3;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [NUM_EN-1:0]    en_vec_t;

endpackage

// File: rtl/dmairq_flag_bank.sv
module dmairq_flag_bank
    import dmairq_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] flag_next
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // set wins over clear in the same cycle
        assign flag_next[i] = set_vec[i] | (flag_q[i] & ~clr_vec[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else begin
                flag_q[i] <= flag_next[i];
            end
        end
    end

endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  flag_vec_t        flag_q,
    output flag_vec_t        clr_vec,
    output en_vec_t          en_q,
    output en_vec_t          en_next,
    output logic [REG_W-1:0] reg_rdata
);

    logic wr0;
    logic wr1;

    assign wr0 = reg_wr & ~reg_sel;
    assign wr1 = reg_wr &  reg_sel;

    always_comb begin
        clr_vec           = '0;
        clr_vec[FL_DONE]  = wr0 & ~reg_wdata[R0_DONE];
        clr_vec[FL_ERR0]  = wr0 & ~reg_wdata[R0_ERR0];
        clr_vec[FL_ERR1]  = wr0 & ~reg_wdata[R0_ERR1];
        clr_vec[FL_WARN0] = wr0 & ~reg_wdata[R0_WARN0];
        clr_vec[FL_WARN1] = wr0 & ~reg_wdata[R0_WARN1];
        clr_vec[FL_EOP]   = wr1 & ~reg_wdata[R1_EOP];
        clr_vec[FL_REP]   = wr1 & ~reg_wdata[R1_REP];
    end

    always_comb begin
        en_next = en_q;
        if (wr0) begin
            en_next[EN_WARN] = reg_wdata[R0_WEN];
        end
        if (wr1) begin
            en_next[EN_REP] = reg_wdata[R1_REPEN];
            en_next[EN_EOP] = reg_wdata[R1_EOPEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[R0_DONE]  = flag_q[FL_DONE];
            reg_rdata[R0_ERR0]  = flag_q[FL_ERR0];
            reg_rdata[R0_ERR1]  = flag_q[FL_ERR1];
            reg_rdata[R0_WARN0] = flag_q[FL_WARN0];
            reg_rdata[R0_WARN1] = flag_q[FL_WARN1];
            reg_rdata[R0_WEN]   = en_q[EN_WARN];
        end else begin
            reg_rdata[R1_EOP]   = flag_q[FL_EOP];
            reg_rdata[R1_EOPEN] = en_q[EN_EOP];
            reg_rdata[R1_REP]   = flag_q[FL_REP];
            reg_rdata[R1_REPEN] = en_q[EN_REP];
        end
    end

endmodule

// File: rtl/dmairq_req_fsm.sv
module dmairq_req_fsm
    import dmairq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t flag_next,
    input  en_vec_t   en_next,
    output logic      irq_req
);

    irq_state_e state_q;
    irq_state_e state_next;
    flag_vec_t  gate;
    logic       pending;

    // ungated sources carry a constant 1 gate
    always_comb begin
        gate           = '1;
        gate[FL_WARN0] = en_next[EN_WARN];
        gate[FL_WARN1] = en_next[EN_WARN];
        gate[FL_REP]   = en_next[EN_REP];
        gate[FL_EOP]   = en_next[EN_EOP];
    end

    assign pending = |(flag_next & gate);

    always_comb begin
        state_next = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_next = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_next = IRQ_QUIET;
            default:    state_next = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_next;
        end
    end

    always_comb begin
        irq_req = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic [1:0]       ev_warn,
    input  logic [1:0]       ev_err,
    input  logic             ev_rep,
    input  logic             ev_eop,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req
);

    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flag_q;
    flag_vec_t flag_next;
    en_vec_t   en_q;
    en_vec_t   en_next;

    always_comb begin
        set_vec           = '0;
        set_vec[FL_DONE]  = ev_done;
        set_vec[FL_ERR0]  = ev_err[0];
        set_vec[FL_ERR1]  = ev_err[1];
        set_vec[FL_WARN0] = ev_warn[0];
        set_vec[FL_WARN1] = ev_warn[1];
        set_vec[FL_REP]   = ev_rep;
        set_vec[FL_EOP]   = ev_eop;
    end

    dmairq_flag_bank #(.N(NUM_FLAGS)) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .flag_q    (flag_q),
        .flag_next (flag_next)
    );

    dmairq_regif regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .flag_q    (flag_q),
        .clr_vec   (clr_vec),
        .en_q      (en_q),
        .en_next   (en_next),
        .reg_rdata (reg_rdata)
    );

    dmairq_req_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_next (flag_next),
        .en_next   (en_next),
        .irq_req   (irq_req)
    );

endmodule

// File: rtl/dmairq_agg_chk.sv
module dmairq_agg_chk
    import dmairq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input flag_vec_t set_vec,
    input logic      reg_wr,
    input flag_vec_t flag_q,
    input en_vec_t   en_q,
    input logic      irq_req
);

    // R2 / R4: every pulsed flag is set after the edge, even under a clear
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

    // R3: without a write no flag can fall
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R5: ungated flags always request
    assert_ungated_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FL_DONE] | flag_q[FL_ERR0] | flag_q[FL_ERR1]) |-> irq_req);

    // R6: warnings alone with the shared enable off do not request
    assert_warn_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[EN_WARN] && ((flag_q & ~(flag_vec_t'(1) << FL_WARN0)
                                    & ~(flag_vec_t'(1) << FL_WARN1)) == '0))
        |-> !irq_req);

    // R7: repeat and end-of-operation flags alone with enables off do not request
    assert_cfg_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[EN_REP] && !en_q[EN_EOP] &&
         ((flag_q & ~(flag_vec_t'(1) << FL_REP)
                  & ~(flag_vec_t'(1) << FL_EOP)) == '0))
        |-> !irq_req);

    // R9: no flags, no request
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> !irq_req);

endmodule

bind dmairq_agg dmairq_agg_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .reg_wr  (reg_wr),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .irq_req (irq_req)
);

// File: tb/dmairq_agg_tb_top.sv
`timescale 1ns/1ps
module dmairq_agg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_done = 1'b0;
    logic [1:0] ev_warn = 2'b00;
    logic [1:0] ev_err = 2'b00;
    logic       ev_rep = 1'b0;
    logic       ev_eop = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    bit finished = 1'b0;

    // reference model state
    bit m_done, m_err0, m_err1, m_warn0, m_warn1, m_rep, m_eop;
    bit m_wen, m_repen, m_eopen;

    always #4 clk = ~clk;

    dmairq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_warn(ev_warn),
        .ev_err(ev_err), .ev_rep(ev_rep), .ev_eop(ev_eop), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    function automatic bit model_irq();
        return m_done | m_err0 | m_err1 | (m_wen & (m_warn0 | m_warn1))
             | (m_repen & m_rep) | (m_eopen & m_eop);
    endfunction

    function automatic logic [7:0] model_rd(bit sel);
        logic [7:0] v = 8'h00;
        if (!sel) v = {2'b00, m_wen, m_warn1, m_warn0, m_err1, m_err0, m_done};
        else      v = {4'h0, m_repen, m_rep, m_eopen, m_eop};
        return v;
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model update and per-clock comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_done, m_err0, m_err1, m_warn0, m_warn1, m_rep, m_eop} = '0;
            {m_wen, m_repen, m_eopen} = '0;
        end else begin
            if (reg_wr && !reg_sel) begin
                if (!reg_wdata[0]) m_done = 0;
                if (!reg_wdata[1]) m_err0 = 0;
                if (!reg_wdata[2]) m_err1 = 0;
                if (!reg_wdata[3]) m_warn0 = 0;
                if (!reg_wdata[4]) m_warn1 = 0;
                m_wen = reg_wdata[5];
            end
            if (reg_wr && reg_sel) begin
                if (!reg_wdata[0]) m_eop = 0;
                m_eopen = reg_wdata[1];
                if (!reg_wdata[2]) m_rep = 0;
                m_repen = reg_wdata[3];
            end
            if (ev_done)    m_done = 1;
            if (ev_err[0])  m_err0 = 1;
            if (ev_err[1])  m_err1 = 1;
            if (ev_warn[0]) m_warn0 = 1;
            if (ev_warn[1]) m_warn1 = 1;
            if (ev_rep)     m_rep = 1;
            if (ev_eop)     m_eop = 1;
        end
        #2;
        check(phase, "irq_req", {7'b0, irq_req}, {7'b0, model_irq()});
        check(phase, "reg_rdata", reg_rdata, model_rd(reg_sel));
    end

    task automatic idle();
        @(negedge clk);
        ev_done = 0; ev_warn = 0; ev_err = 0; ev_rep = 0; ev_eop = 0;
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        idle();
    endtask

    // sample one cycle after stimulus, away from edges
    task automatic expect_now(string req, bit sel, logic [7:0] rd, bit irq);
        @(negedge clk);
        reg_sel = sel;
        #1;
        check(req, "rdata", reg_rdata, rd);
        check(req, "irq", {7'b0, irq_req}, {7'b0, irq});
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        phase = "R1";
        expect_now("R1", 0, 8'h00, 0);
        expect_now("R1", 1, 8'h00, 0);
        rst_n = 1;
        expect_now("R1", 0, 8'h00, 0);

        // R2 / R5: completion pulse sets sticky flag, raises irq
        phase = "R2";
        @(negedge clk); ev_done = 1; idle();
        expect_now("R2", 0, 8'h01, 1);
        expect_now("R5", 0, 8'h01, 1);
        // R3: writing 1 keeps, writing 0 clears
        phase = "R3";
        wr(0, 8'h01);
        expect_now("R3", 0, 8'h01, 1);
        wr(0, 8'h00);
        expect_now("R3", 0, 8'h00, 0);

        // R5: error flags
        phase = "R5";
        @(negedge clk); ev_err = 2'b10; idle();
        expect_now("R5", 0, 8'h04, 1);
        wr(0, 8'h00);
        expect_now("R5", 0, 8'h00, 0);

        // R6 / R8: warnings set while disabled, enable raises irq
        phase = "R6";
        @(negedge clk); ev_warn = 2'b01; idle();
        expect_now("R6", 0, 8'h08, 0);
        wr(0, 8'h28);
        expect_now("R8", 0, 8'h28, 1);
        wr(0, 8'h20);
        expect_now("R6", 0, 8'h20, 0);
        @(negedge clk); ev_warn = 2'b10; idle();
        expect_now("R6", 0, 8'h30, 1);
        wr(0, 8'h10);
        expect_now("R8", 0, 8'h10, 0);
        wr(0, 8'h00);

        // R7: repeat and end-of-operation gating
        phase = "R7";
        @(negedge clk); ev_rep = 1; ev_eop = 1; idle();
        expect_now("R7", 1, 8'h05, 0);
        wr(1, 8'h0D);
        expect_now("R7", 1, 8'h0D, 1);
        wr(1, 8'h07);
        expect_now("R7", 1, 8'h07, 1);
        wr(1, 8'h05);
        expect_now("R7", 1, 8'h05, 0);
        // R3: writes to register 0 leave register 1 flags
        wr(0, 8'h00);
        expect_now("R3", 1, 8'h05, 0);

        // R4: event collides with clear
        phase = "R4";
        @(negedge clk); ev_rep = 1; reg_wr = 1; reg_sel = 1; reg_wdata = 8'h08; idle();
        expect_now("R4", 1, 8'h0C, 1);
        wr(1, 8'h00);
        expect_now("R4", 1, 8'h00, 0);

        // R10: unused bits
        phase = "R10";
        wr(1, 8'hF0);
        expect_now("R10", 1, 8'h00, 0);
        wr(0, 8'hC0);
        expect_now("R10", 0, 8'h00, 0);

        // R9: random mix, compared every clock
        phase = "R9";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            ev_done   = ($urandom_range(0, 15) == 0);
            ev_warn   = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            ev_err    = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            ev_rep    = ($urandom_range(0, 9) == 0);
            ev_eop    = ($urandom_range(0, 9) == 0);
            reg_wr    = ($urandom_range(0, 3) == 0);
            reg_sel   = 1'($urandom);
            reg_wdata = 8'($urandom);
        end
        idle();
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule